// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Unit

This unit serves a set of harts through a small 32-bit register bus. It holds one 64-bit time counter, shared by all harts, that advances by one on every cycle in which the timebase strobe is high. Each hart has its own 64-bit compare register and its own one-bit software interrupt flag. For each hart the unit drives two lines: a timer interrupt and a software interrupt.

The timer interrupt of a hart is high in every cycle in which that hart's compare value is less than or equal to the time counter. The result is a plain combinational compare of two registers, so it needs no write to update it. Software raises or clears a hart's software interrupt by writing bit 0 of that hart's flag word. Software can move a compare value one 32-bit half at a time, and the other half keeps its value. Three parameters set where the three windows sit in the address space: the flag array (4 bytes per hart), the compare array (8 bytes per hart, low half at +0, high half at +4) and the time counter (low half at +0, high half at +4).

Bus accesses are handled by a two-state machine. ACC_IDLE moves to ACC_RESP when `sel` is high. ACC_RESP stays in ACC_RESP when `sel` is high again, and returns to ACC_IDLE when `sel` is low. `ack`, `rdata` and `err` are valid in the ACC_RESP state.

Top module: `hart_timer_swi`

## Requirements
- R1: After reset, every compare register is 0 and so is the time counter. Every timer interrupt line is therefore high, every software interrupt line is low, and `ack` and `err` are low.
- R2: The time counter goes up by exactly one for each clock edge at which `tick` is high. It holds its value when `tick` is low.
- R3: A read at TIME_BASE returns time bits 31:0. A read at TIME_BASE+4 returns time bits 63:32. Writes to either of these words have no effect on the counter.
- R4: The flag word of hart h sits at SWI_BASE+4*h. Writing it sets that hart's software interrupt line to bit 0 of the write data. Reading it returns the line state in bit 0, with all other bits 0.
- R5: The compare entry of hart h sits at CMP_BASE+8*h. Offset 0 holds bits 31:0 and offset 4 holds bits 63:32. Writing one half replaces only that half, and both halves read back what was written.
- R6: Timer interrupt h is high exactly when compare h is less than or equal to the time counter. It goes low once the compare value is moved into the future, and it goes high in the cycle in which the time counter reaches the compare value.
- R7: An access to an unmapped address, or to an offset inside an entry that is not a defined word, returns 0 on `rdata` and raises `err` together with `ack` for one cycle. A write to such an address changes no state.
- R8: An access accepted at a clock edge (with `sel` high) gives `ack` high for the following cycle, with `rdata` and `err` valid in that cycle. Writes take effect at the accepting edge, and a write access returns 0 on `rdata`.
- R9: A write to one hart's flag or compare register leaves the registers of every other hart unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe; each high cycle adds one to the time counter |
| sel | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (16) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `ack` is high |
| ack | output | 1 | High in the cycle after an accepted access |
| err | output | 1 | High with `ack` when the access hit an unmapped or misaligned address |
| tmr_irq | output | NUM_HARTS (4) | Per-hart timer interrupt |
| swi_irq | output | NUM_HARTS (4) | Per-hart software interrupt |

## Verification
Bus results (`ack`, `rdata`, `err`) are due one cycle after the edge that accepts `sel`. The bench drives each access on a falling edge, lets one rising edge pass, and samples on the next falling edge. Register effects appear at the accepting edge. The software interrupt lines are registered, so they can be checked on the falling edge after a write. The timer interrupt lines follow the compare and time registers with no extra register stage, so each check of them is placed on the falling edge just after the tick or write edge that should flip them. The time counter is read back through the bus after a known number of tick edges, which shows how many edges were counted.

// File: rtl/hti_pkg.sv
package hti_pkg;

    // Kind of register an address selects; K_NONE means unmapped or misaligned.
    typedef enum logic [2:0] {
        K_NONE,
        K_SWI,
        K_CMP_LO,
        K_CMP_HI,
        K_TIME_LO,
        K_TIME_HI
    } reg_kind_e;

    // Bus access state machine.
    typedef enum logic {
        ACC_IDLE,
        ACC_RESP
    } acc_state_e;

endpackage

// File: rtl/hti_addr_dec.sv
module hti_addr_dec
    import hti_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned IDX_W     = 2,
    parameter int unsigned SWI_BASE  = 32'h0000,
    parameter int unsigned CMP_BASE  = 32'h4000,
    parameter int unsigned TIME_BASE = 32'hBFF8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  hart_idx
);

    localparam logic [ADDR_W-1:0] SWI_B    = ADDR_W'(SWI_BASE);
    localparam logic [ADDR_W-1:0] CMP_B    = ADDR_W'(CMP_BASE);
    localparam logic [ADDR_W-1:0] TIME_LOA = ADDR_W'(TIME_BASE);
    localparam logic [ADDR_W-1:0] TIME_HIA = ADDR_W'(TIME_BASE + 4);
    localparam logic [ADDR_W-1:0] SWI_SPAN = ADDR_W'(NUM_HARTS * 4);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(NUM_HARTS * 8);

    logic [ADDR_W-1:0] swi_off;
    logic [ADDR_W-1:0] cmp_off;

    // Subtraction wraps for addresses below a base, so they fail the span test.
    assign swi_off = addr - SWI_B;
    assign cmp_off = addr - CMP_B;

    always_comb begin
        kind     = K_NONE;
        hart_idx = '0;
        if (swi_off < SWI_SPAN) begin
            hart_idx = IDX_W'(swi_off >> 2);
            if (swi_off[1:0] == 2'b00) begin
                kind = K_SWI;
            end
        end else if (cmp_off < CMP_SPAN) begin
            hart_idx = IDX_W'(cmp_off >> 3);
            unique case (cmp_off[2:0])
                3'd0:    kind = K_CMP_LO;
                3'd4:    kind = K_CMP_HI;
                default: kind = K_NONE;
            endcase
        end else if (addr == TIME_LOA) begin
            kind = K_TIME_LO;
        end else if (addr == TIME_HIA) begin
            kind = K_TIME_HI;
        end
    end

endmodule

// File: rtl/hti_timebase.sv
module hti_timebase #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hti_hart_slot.sv
module hti_hart_slot #(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_swi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  now,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              swi_q,
    output logic              tmr_irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            swi_q <= 1'b0;
        end else begin
            if (wr_lo) begin
                cmp_q[DATA_W-1:0] <= wdata;
            end
            if (wr_hi) begin
                cmp_q[CNT_W-1:DATA_W] <= wdata[CNT_W-DATA_W-1:0];
            end
            if (wr_swi) begin
                swi_q <= wdata[0];
            end
        end
    end

    // Compared in every cycle, not only when a register is written.
    assign tmr_irq = (cmp_q <= now);

endmodule

// File: rtl/hart_timer_swi.sv
module hart_timer_swi
    import hti_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SWI_BASE  = 32'h0000,
    parameter int unsigned CMP_BASE  = 32'h4000,
    parameter int unsigned TIME_BASE = 32'hBFF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic                 ack,
    output logic                 err,
    output logic [NUM_HARTS-1:0] tmr_irq,
    output logic [NUM_HARTS-1:0] swi_irq
);

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned IDX_W  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    reg_kind_e        kind;
    logic [IDX_W-1:0] hart_idx;
    logic [CNT_W-1:0] time_q;
    logic [CNT_W-1:0] cmp_arr [NUM_HARTS];
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic             err_q;
    logic             wr_go;
    acc_state_e       state_q;
    acc_state_e       state_d;

    hti_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_HARTS(NUM_HARTS),
        .IDX_W    (IDX_W),
        .SWI_BASE (SWI_BASE),
        .CMP_BASE (CMP_BASE),
        .TIME_BASE(TIME_BASE)
    ) u_dec (
        .addr    (addr),
        .kind    (kind),
        .hart_idx(hart_idx)
    );

    hti_timebase #(.CNT_W(CNT_W)) u_time (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .count(time_q)
    );

    assign wr_go = sel && we;

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
        logic hit;
        assign hit = (hart_idx == IDX_W'(g));
        hti_hart_slot #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_swi (wr_go && hit && (kind == K_SWI)),
            .wr_lo  (wr_go && hit && (kind == K_CMP_LO)),
            .wr_hi  (wr_go && hit && (kind == K_CMP_HI)),
            .wdata  (wdata),
            .now    (time_q),
            .cmp_q  (cmp_arr[g]),
            .swi_q  (swi_irq[g]),
            .tmr_irq(tmr_irq[g])
        );
    end

    // Read data selection; writes and unmapped kinds yield zero.
    always_comb begin
        rd_mux = '0;
        if (!we) begin
            unique case (kind)
                K_SWI:     rd_mux = {{(DATA_W-1){1'b0}}, swi_irq[hart_idx]};
                K_CMP_LO:  rd_mux = cmp_arr[hart_idx][DATA_W-1:0];
                K_CMP_HI:  rd_mux = cmp_arr[hart_idx][CNT_W-1:DATA_W];
                K_TIME_LO: rd_mux = time_q[DATA_W-1:0];
                K_TIME_HI: rd_mux = time_q[CNT_W-1:DATA_W];
                K_NONE:    rd_mux = '0;
                default:   rd_mux = '0;
            endcase
        end
    end

    // Next-state logic of the access machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = sel ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = sel ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers of the access machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (sel) begin
            rdata_q <= rd_mux;
            err_q   <= (kind == K_NONE);
        end else begin
            err_q   <= 1'b0;
        end
    end

    assign ack   = (state_q == ACC_RESP);
    assign err   = ack && err_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/hart_timer_swi_chk.sv
module hart_timer_swi_chk #(
    parameter int unsigned NUM_HARTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 sel,
    input logic                 ack,
    input logic                 err,
    input logic [31:0]          rdata,
    input logic [NUM_HARTS-1:0] tmr_irq,
    input logic [NUM_HARTS-1:0] swi_irq,
    input logic [63:0]          now
);

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (now == $past(now) + 64'd1));

    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(now));

    p_ack_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> ack);

    p_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !ack);

    p_err_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);

    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == 32'd0));

    p_swi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(swi_irq));

    // With no bus write, time only grows, so a raised timer line stays raised.
    p_tmr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ((tmr_irq & $past(tmr_irq)) == $past(tmr_irq)));

endmodule

bind hart_timer_swi hart_timer_swi_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .sel    (sel),
    .ack    (ack),
    .err    (err),
    .rdata  (rdata),
    .tmr_irq(tmr_irq),
    .swi_irq(swi_irq),
    .now    (time_q)
);

// File: tb/hart_timer_swi_test.sv
`timescale 1ns/1ps
module hart_timer_swi_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        err;
    logic [3:0]  tmr_irq;
    logic [3:0]  swi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hart_timer_swi uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack), .err(err),
        .tmr_irq(tmr_irq), .swi_irq(swi_irq)
    );

    // Row: [85:82] requirement, [81] we, [80:65] addr, [64:33] wdata,
    //      [32:1] expected rdata, [0] expected err
    localparam int NROW = 21;
    localparam logic [85:0] TBL [NROW] = '{
        {4'd1, 1'b0, 16'h0000, 32'h0,        32'h0,        1'b0}, // R1 flag reset
        {4'd4, 1'b1, 16'h0008, 32'h1,        32'h0,        1'b0}, // R4 set hart2
        {4'd4, 1'b0, 16'h0008, 32'h0,        32'h1,        1'b0}, // R4 read hart2
        {4'd9, 1'b0, 16'h0004, 32'h0,        32'h0,        1'b0}, // R9 hart1 untouched
        {4'd7, 1'b1, 16'h0002, 32'h1,        32'h0,        1'b1}, // R7 misaligned write
        {4'd7, 1'b0, 16'h0000, 32'h0,        32'h0,        1'b0}, // R7 write ignored
        {4'd5, 1'b1, 16'h4008, 32'h11110000, 32'h0,        1'b0}, // R5 hart1 lo
        {4'd5, 1'b1, 16'h400C, 32'h00000002, 32'h0,        1'b0}, // R5 hart1 hi
        {4'd5, 1'b0, 16'h4008, 32'h0,        32'h11110000, 1'b0},
        {4'd5, 1'b0, 16'h400C, 32'h0,        32'h00000002, 1'b0},
        {4'd5, 1'b1, 16'h4008, 32'hAAAA5555, 32'h0,        1'b0},
        {4'd5, 1'b0, 16'h400C, 32'h0,        32'h00000002, 1'b0}, // R5 hi kept
        {4'd5, 1'b0, 16'h4008, 32'h0,        32'hAAAA5555, 1'b0},
        {4'd7, 1'b0, 16'h4009, 32'h0,        32'h0,        1'b1}, // R7 inside entry
        {4'd7, 1'b0, 16'h8000, 32'h0,        32'h0,        1'b1}, // R7 unmapped
        {4'd3, 1'b1, 16'hBFF8, 32'hFFFFFFFF, 32'h0,        1'b0}, // R3 write time
        {4'd3, 1'b0, 16'hBFF8, 32'h0,        32'h0,        1'b0}, // R3 still 0
        {4'd3, 1'b0, 16'hBFFC, 32'h0,        32'h0,        1'b0},
        {4'd7, 1'b0, 16'h4020, 32'h0,        32'h0,        1'b1}, // R7 past compares
        {4'd7, 1'b0, 16'h0010, 32'h0,        32'h0,        1'b1}, // R7 past flags
        {4'd9, 1'b0, 16'h4018, 32'h0,        32'h0,        1'b0}  // R9 hart3 cmp still 0
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er, output logic ak);
        @(negedge clk);
        sel = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd = rdata; er = err; ak = ack;
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        logic        ak;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: compares and time at 0 so timer lines high, flags low
        check("R1 tmr_irq", 64'(tmr_irq), 64'hF);
        check("R1 swi_irq", 64'(swi_irq), 64'h0);
        check("R1 ack", 64'(ack), 64'h0);
        check("R1 err", 64'(err), 64'h0);

        for (int i = 0; i < NROW; i++) begin
            access(TBL[i][81], TBL[i][80:65], TBL[i][64:33], rd, er, ak);
            check($sformatf("R%0d row%0d rdata", TBL[i][85:82], i), 64'(rd), 64'(TBL[i][32:1]));
            check($sformatf("R%0d row%0d err", TBL[i][85:82], i), 64'(er), 64'(TBL[i][0]));
            check($sformatf("R8 row%0d ack", i), 64'(ak), 64'h1);
        end

        // R8/R7: one cycle after the last access, ack and err are low again
        @(negedge clk);
        check("R8 ack drop", 64'(ack), 64'h0);
        check("R7 err pulse", 64'(err), 64'h0);
        // R4, R9: only hart2 flag is set
        check("R4 swi_irq", 64'(swi_irq), 64'h4);
        // R6: hart1 compare now in the future
        check("R6 tmr_irq after cmp", 64'(tmr_irq), 64'hD);

        // R2: five ticks give time 5
        ticks(5);
        access(1'b0, 16'hBFF8, 32'h0, rd, er, ak);
        check("R2 time after 5 ticks", 64'(rd), 64'd5);
        @(negedge clk);
        access(1'b0, 16'hBFF8, 32'h0, rd, er, ak);
        check("R2 time held", 64'(rd), 64'd5);

        // R6: hart0 compare = 10, future -> low
        access(1'b1, 16'h4000, 32'd10, rd, er, ak);
        check("R6 hart0 low", 64'(tmr_irq[0]), 64'h0);
        ticks(4);
        check("R6 hart0 at 9", 64'(tmr_irq[0]), 64'h0);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R6 hart0 at 10", 64'(tmr_irq[0]), 64'h1);
        // R5/R6: raise high half only, compare moves far ahead
        access(1'b1, 16'h4004, 32'd1, rd, er, ak);
        check("R6 hart0 after hi write", 64'(tmr_irq[0]), 64'h0);
        access(1'b0, 16'h4000, 32'h0, rd, er, ak);
        check("R5 hart0 lo kept", 64'(rd), 64'd10);
        // R4: clear hart2 flag
        access(1'b1, 16'h0008, 32'h0, rd, er, ak);
        check("R4 clear", 64'(swi_irq), 64'h0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule